// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates six level-sensitive interrupt requests for a small 8-bit core: two external lines, two timers, a serial port and an expansion line. Software programs two 8-bit registers over a simple write/read bus. The first holds a per-source enable mask plus one global enable. The second holds one priority bit per source. The controller picks one winning source. It raises a request to the core and presents that source's vector address. When the core takes the request, the controller sends a one-cycle acknowledge pulse back to the winning source.

Two in-service flags, one per priority level, provide nesting. Once a low-level handler is entered, only a high-level request can interrupt it. Once a high-level handler is entered, nothing can interrupt it. A return pulse from the core closes the innermost open level. The request output is registered. It is held low for one cycle after any event that changes arbitration state, so the core never sees a request that was computed from stale registers or stale flags.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq_o` is 0, `src_ack_o` is 0, and both registers read as 0x00.
- R2: Address 0 is the enable register and address 1 is the priority register. In the enable register, bits 0..5 enable the sources in this order: ext0, tmr0, ext1, tmr1, ser0, exp1. Bit 7 is the global enable, and bit 6 always reads 0. In the priority register, bits 0..5 follow the same source order, and bits 6 and 7 read 0.
- R3: While the global enable is 0, `cpu_irq_o` stays 0 whatever the requests and enable bits.
- R4: A source whose own enable bit is 0 never wins, even while it requests.
- R5: A priority bit of 1 places a source at the high level and 0 at the low level. When both levels have eligible requests, a high-level source wins.
- R6: Among eligible requests at the same level, the source with the lowest bit index wins.
- R7: While `cpu_irq_o` is 1, `cpu_vec_o` equals 0x0003 + 8 × (index of the winner). This gives 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B.
- R8: While the low in-service flag alone is set, only high-level sources can raise `cpu_irq_o`. While the high flag is set, no source can.
- R9: A take is `cpu_take_i` high while `cpu_irq_o` is 1. A take sets the in-service flag of the winner's level, as that level stood before any write in the same cycle. In the same cycle it drives `src_ack_o` one-hot on the winner's bit; otherwise `src_ack_o` is 0.
- R10: A `reti_i` pulse clears the high in-service flag if it is set, and otherwise clears the low flag. If a take and a return occur in the same cycle, the clear is applied first and the take then sets its flag.
- R11: In the cycle after a `reti_i` pulse, a register write or a take, `cpu_irq_o` is 0.
- R12: Outside those cycles, `cpu_irq_o` and `cpu_vec_o` reflect the requests, registers and flags of the previous cycle, one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 enable, 1 priority |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register (combinational) |
| src_req_i | input | 6 | Level request from each source |
| src_ack_o | output | 6 | One-cycle acknowledge, one-hot on the taken source |
| reti_i | input | 1 | Return-from-handler pulse from the core |
| cpu_take_i | input | 1 | Core accepts the pending request |
| cpu_irq_o | output | 1 | Request to the core |
| cpu_vec_o | output | 16 | Vector address of the winning source |

## Verification
A request change becomes visible on `cpu_irq_o` and `cpu_vec_o` after exactly one rising edge. A register write takes two edges: one to load the register and a held-off cycle before the next arbitration. The acknowledge is combinational in the take cycle, and register reads are combinational. The bench drives every input just after a falling edge. It checks `src_ack_o` and `bus_rdata_o` 1 ns later, before the rising edge. It checks the request and vector at the following falling edge, against a model that advances its flags and registers once per edge in the order that R9 and R10 fix.

// File: rtl/nic_pkg.sv
package nic_pkg;

   localparam logic ADDR_EN  = 1'b0;
   localparam logic ADDR_PRI = 1'b1;

   typedef enum logic {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } nic_lvl_e;

   function automatic logic [31:0] nic_vector(input logic [31:0] idx,
                                              input logic [31:0] base,
                                              input logic [31:0] stride);
      return base + idx * stride;
   endfunction

endpackage

// File: rtl/nic_regs.sv
module nic_regs #(
   parameter int NUM_SRC = 6,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic               addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic [NUM_SRC-1:0] en_o,
   output logic               ea_o,
   output logic [NUM_SRC-1:0] pri_o
);
   import nic_pkg::*;

   localparam int EA_BIT = DATA_W - 1;

   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] pri_q;
   logic               ea_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pri_q <= '0;
         ea_q  <= 1'b0;
      end else if (wr_i) begin
         if (addr_i == ADDR_EN) begin
            en_q <= wdata_i[NUM_SRC-1:0];
            ea_q <= wdata_i[EA_BIT];
         end else begin
            pri_q <= wdata_i[NUM_SRC-1:0];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_EN) begin
         rdata_o[NUM_SRC-1:0] = en_q;
         rdata_o[EA_BIT]      = ea_q;
      end else begin
         rdata_o[NUM_SRC-1:0] = pri_q;
      end
   end

   assign en_o  = en_q;
   assign ea_o  = ea_q;
   assign pri_o = pri_q;

endmodule

// File: rtl/nic_pick.sv
module nic_pick #(
   parameter int N     = 6,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [N-1:0] lowest;

   assign lowest = req_i & (~req_i + N'(1));
   assign any_o  = |req_i;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (lowest[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/nic_nest.sv
module nic_nest (
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic take_hi_i,
   input  logic reti_i,
   output logic isr_hi_o,
   output logic isr_lo_o
);
   logic hi_q, lo_q;
   logic hi_d, lo_d;

   always_comb begin
      hi_d = hi_q;
      lo_d = lo_q;
      if (reti_i) begin
         if (hi_q) hi_d = 1'b0;
         else      lo_d = 1'b0;
      end
      if (take_i) begin
         if (take_hi_i) hi_d = 1'b1;
         else           lo_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hi_d;
         lo_q <= lo_d;
      end
   end

   assign isr_hi_o = hi_q;
   assign isr_lo_o = lo_q;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
   parameter int NUM_SRC    = 6,
   parameter int DATA_W     = 8,
   parameter int VEC_W      = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr_i,
   input  logic               bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   input  logic [NUM_SRC-1:0] src_req_i,
   output logic [NUM_SRC-1:0] src_ack_o,
   input  logic               reti_i,
   input  logic               cpu_take_i,
   output logic               cpu_irq_o,
   output logic [VEC_W-1:0]   cpu_vec_o
);
   import nic_pkg::*;

   localparam int IDX_W    = $clog2(NUM_SRC);
   localparam int VEC_LAST = VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE;

   if (NUM_SRC < 2 || NUM_SRC > DATA_W - 1) begin : g_bad_src
      $error("NUM_SRC must lie between 2 and DATA_W-1");
   end
   if (VEC_W < 32 && VEC_LAST >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector table does not fit in VEC_W bits");
   end

   logic [NUM_SRC-1:0] en_w, pri_w;
   logic               ea_w;
   logic               isr_hi_w, isr_lo_w;

   nic_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .rdata_o (bus_rdata_o),
      .en_o    (en_w),
      .ea_o    (ea_w),
      .pri_o   (pri_w)
   );

   // eligibility per level, gated by the open/closed state of each level
   logic [NUM_SRC-1:0] elig, hi_cand, lo_cand;
   logic               hi_open, lo_open;

   assign hi_open = ~isr_hi_w;
   assign lo_open = ~isr_hi_w & ~isr_lo_w;
   assign elig    = src_req_i & en_w & {NUM_SRC{ea_w}};
   assign hi_cand = elig &  pri_w & {NUM_SRC{hi_open}};
   assign lo_cand = elig & ~pri_w & {NUM_SRC{lo_open}};

   logic             hi_any, lo_any;
   logic [IDX_W-1:0] hi_idx, lo_idx;

   nic_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick_hi (
      .req_i (hi_cand),
      .any_o (hi_any),
      .idx_o (hi_idx)
   );

   nic_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick_lo (
      .req_i (lo_cand),
      .any_o (lo_any),
      .idx_o (lo_idx)
   );

   logic             win_valid;
   logic [IDX_W-1:0] win_idx;

   assign win_valid = hi_any | lo_any;
   assign win_idx   = hi_any ? hi_idx : lo_idx;

   // registered request to the core
   logic             irq_q;
   logic [IDX_W-1:0] id_q;
   logic             take_hit, hold_off;
   nic_lvl_e         take_lvl;

   assign take_hit = cpu_take_i & irq_q;
   assign hold_off = reti_i | bus_wr_i | take_hit;
   assign take_lvl = pri_w[id_q] ? LVL_HI : LVL_LO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         id_q  <= '0;
      end else begin
         irq_q <= win_valid & ~hold_off;
         if (win_valid) id_q <= win_idx;
      end
   end

   nic_nest u_nest (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_i    (take_hit),
      .take_hi_i (take_lvl == LVL_HI),
      .reti_i    (reti_i),
      .isr_hi_o  (isr_hi_w),
      .isr_lo_o  (isr_lo_w)
   );

   assign cpu_irq_o = irq_q;
   assign cpu_vec_o = irq_q ? VEC_W'(nic_vector(32'(id_q), 32'(VEC_BASE), 32'(VEC_STRIDE)))
                            : '0;
   assign src_ack_o = take_hit ? (NUM_SRC'(1) << id_q) : '0;

endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
   parameter int NUM_SRC = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_irq_o,
   input logic               cpu_take_i,
   input logic               reti_i,
   input logic               bus_wr_i,
   input logic [NUM_SRC-1:0] src_ack_o,
   input logic               ea_i,
   input logic               isr_hi_i,
   input logic               isr_lo_i
);

   a_r3_ea_gates: assert property (@(posedge clk) disable iff (!rst_n)
      !ea_i |=> !cpu_irq_o);

   a_r8_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
      isr_hi_i |-> !cpu_irq_o);

   a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i || bus_wr_i || (cpu_take_i && cpu_irq_o)) |=> !cpu_irq_o);

   a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_ack_o));

   a_r9_take_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_take_i && cpu_irq_o && !reti_i) |=> (isr_hi_i || isr_lo_i));

   a_r10_reti_closes_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && isr_hi_i && !(cpu_take_i && cpu_irq_o)) |=> (!isr_hi_i && (isr_lo_i == $past(isr_lo_i))));

endmodule

bind nest_irq_ctrl nic_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_irq_o  (cpu_irq_o),
   .cpu_take_i (cpu_take_i),
   .reti_i     (reti_i),
   .bus_wr_i   (bus_wr_i),
   .src_ack_o  (src_ack_o),
   .ea_i       (ea_w),
   .isr_hi_i   (isr_hi_w),
   .isr_lo_i   (isr_lo_w)
);

// File: tb/nest_irq_ctrl_tb.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [5:0] src_req = '0;
   logic [5:0] src_ack;
   logic       reti = 1'b0;
   logic       cpu_take = 1'b0;
   logic       cpu_irq;
   logic [15:0] cpu_vec;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   nest_irq_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .src_req_i   (src_req),
      .src_ack_o   (src_ack),
      .reti_i      (reti),
      .cpu_take_i  (cpu_take),
      .cpu_irq_o   (cpu_irq),
      .cpu_vec_o   (cpu_vec)
   );

   // model state, built from the requirements
   logic [5:0] m_en = '0, m_pri = '0;
   logic       m_ea = 1'b0, m_hi = 1'b0, m_lo = 1'b0, m_irq = 1'b0;
   int         m_id = 0;

   function automatic int lowest(input logic [5:0] v);
      for (int i = 0; i < 6; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic read_chk(input string tag, input logic a);
      bus_wr = 1'b0;
      bus_addr = a;
      #1;
      check(tag, 32'(bus_rdata), a ? {26'd0, m_pri} : {24'd0, m_ea, 1'b0, m_en});
   endtask

   // called just after a falling edge
   task automatic step(input string tag, input logic [5:0] req, input logic take,
                       input logic rt, input logic wr, input logic a, input logic [7:0] wd);
      logic [5:0] elig, hc, lc;
      int         n_id;
      logic       hold, n_irq;
      src_req = req; cpu_take = take; reti = rt;
      bus_wr = wr; bus_addr = a; bus_wdata = wd;
      #1;
      check({tag, " R9 ack"}, 32'(src_ack), (take && m_irq) ? 32'(6'b1 << m_id) : 32'd0);
      elig = req & m_en & {6{m_ea}};
      hc   = elig &  m_pri & {6{!m_hi}};
      lc   = elig & ~m_pri & {6{!m_hi && !m_lo}};
      n_id = lowest(hc);
      if (n_id < 0) n_id = lowest(lc);
      hold  = rt | wr | (take & m_irq);
      n_irq = (n_id >= 0) && !hold;
      if (rt) begin
         if (m_hi) m_hi = 1'b0;
         else      m_lo = 1'b0;
      end
      if (take && m_irq) begin
         if (m_pri[m_id]) m_hi = 1'b1;
         else             m_lo = 1'b1;
      end
      if (wr) begin
         if (!a) begin m_en = wd[5:0]; m_ea = wd[7]; end
         else    m_pri = wd[5:0];
      end
      m_irq = n_irq;
      if (n_id >= 0) m_id = n_id;
      @(posedge clk);
      @(negedge clk);
      check({tag, " R12 irq"}, 32'(cpu_irq), 32'(m_irq));
      if (m_irq) check({tag, " R7 vec"}, 32'(cpu_vec), 32'(3 + 8 * m_id));
   endtask

   task automatic wr_reg(input string tag, input logic a, input logic [7:0] d);
      step(tag, '0, 1'b0, 1'b0, 1'b1, a, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7121));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", 32'(cpu_irq), 32'd0);
      check("R1 ack", 32'(src_ack), 32'd0);
      read_chk("R1 en reg", 1'b0);
      read_chk("R1 pri reg", 1'b1);

      // R2 register map: bit 6 of enable reads 0, bits 6..7 of priority read 0
      wr_reg("R2", 1'b0, 8'hFF);
      read_chk("R2 en bit6", 1'b0);
      check("R2 en literal", 32'(bus_rdata), 32'h0BF);
      wr_reg("R2", 1'b1, 8'hFF);
      read_chk("R2 pri hi bits", 1'b1);
      check("R2 pri literal", 32'(bus_rdata), 32'h03F);
      wr_reg("R2", 1'b1, 8'h00);

      // R3 global enable off
      wr_reg("R3", 1'b0, 8'h3F);
      for (int k = 0; k < 4; k++) step("R3", 6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      check("R3 literal", 32'(cpu_irq), 32'd0);

      // R4 individual enables off
      wr_reg("R4", 1'b0, 8'h80);
      step("R4", 6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      step("R4", 6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      check("R4 literal", 32'(cpu_irq), 32'd0);

      // R6 / R7 same-level polling and vectors
      wr_reg("R6", 1'b0, 8'hBF);
      step("R6", 6'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      check("R6 literal", 32'(cpu_vec), 32'h13);
      step("R7", 6'h20, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      check("R7 literal", 32'(cpu_vec), 32'h2B);

      // R5 high beats low
      wr_reg("R5", 1'b1, 8'h20);
      step("R5", 6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      check("R5 literal", 32'(cpu_vec), 32'h2B);

      // R8 / R9 / R10 nesting sequence, tmr1 high
      wr_reg("R8", 1'b1, 8'h08);
      step("R9", 6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      step("R9 take lo", 6'h01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0);
      step("R11 after take", 6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      step("R8 lo blocks lo", 6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      check("R8 literal lo", 32'(cpu_irq), 32'd0);
      step("R8 hi preempts", 6'h09, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      check("R8 literal hi", 32'(cpu_vec), 32'h1B);
      step("R9 take hi", 6'h09, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0);
      step("R8 hi blocks all", 6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      step("R8 hi blocks all", 6'h3F, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      step("R10 reti hi", 6'h09, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0);
      step("R10 lo still open", 6'h09, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      check("R10 literal", 32'(cpu_vec), 32'h1B);
      step("R10 reti lo", 6'h01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0);
      step("R10 all open", 6'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0);
      check("R10 literal open", 32'(cpu_vec), 32'h03);
      step("R11 write holds", 6'h01, 1'b0, 1'b0, 1'b1, 1'b1, 8'h08);

      // constrained random mix
      for (int k = 0; k < 4000; k++) begin
         logic [5:0] rq;
         logic tk, rt, wr, ad;
         logic [7:0] wd;
         rq = 6'($urandom);
         tk = ($urandom % 4) == 0;
         rt = (m_hi || m_lo) && (($urandom % 6) == 0);
         wr = ($urandom % 25) == 0;
         ad = 1'($urandom);
         wd = 8'($urandom);
         if (wr && !ad) wd[7] = ($urandom % 5) != 0;
         step("R12 rand", rq, tk, rt, wr, ad, wd);
         if ((k % 200) == 0) begin
            read_chk("R2 rand en", 1'b0);
            read_chk("R2 rand pri", 1'b1);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule